// File: doc/BRIEF.md
# Paired-Channel Conversion Trigger Sequencer

This block sits between a set of trigger pulses and one shared analog-to-digital converter core. Analog inputs are grouped into pairs: pair p owns the even channel 2p and the odd channel 2p+1. Each pair has its own trigger source selector, software trigger bit, interrupt enable, pending flag and sticky ready flag. A trigger that is accepted marks the pair pending. A sequencer then runs the pair's two conversions back to back through a request/done handshake with the converter. It stores both 10-bit results in 16-bit result registers and reports completion.

A few global fields shape every conversion: module enable, conversion order (even first or odd first), interrupt point (after the first or the second conversion of a pair), result justification, and a divider select that sets the period of the conversion clock tick. When several pairs are pending, the lowest-numbered pair is served first, and only one conversion is outstanding at any time.

Top module: `adc_pair_seq`

## Requirements
- R1: While `glb_en` is 0, no pair becomes pending, whatever the trigger inputs or software trigger bits show.
- R2: `eie` takes `eie_wdata` on a cycle with `eie_wr` = 1 only while `glb_en` is 0. Write attempts while `glb_en` is 1 leave it unchanged.
- R3: With `order_odd` = 0, a pair p requests channel 2p on `conv_ch` and then 2p+1. With `order_odd` = 1, it requests 2p+1 and then 2p.
- R4: A pulse on `sw_trig_set[p]` sets `sw_trig[p]` if pair p is not pending. `sw_trig[p]` clears on the same clock edge that sets `pend[p]`. A pulse while `pend[p]` = 1 has no effect.
- R5: `pend[p]` rises one edge after an accepted trigger and stays high until the pair's second conversion completes. It falls on the edge that captures that second `conv_done`. A hardware trigger that arrives while `pend[p]` = 1 starts no extra conversion.
- R6: Pair p's 5-bit source code `src_sel[5p+4:5p]` selects bit `trig_bus[code]` as its hardware trigger. Code 12 (5'b01100) is the timer-1 period-match pulse, and code 0 selects no source. Pulses on other bits of the bus do not trigger the pair.
- R7: `irq[p]` is a single-cycle pulse, and it is raised only when `irq_en[p]` = 1.
- R8: With `eie` = 1, `irq[p]` rises on the edge that stores the pair's first result. With `eie` = 0, it rises on the edge that stores the second result, together with the fall of `pend[p]`.
- R9: `rdy[p]` is set when pair p completes. It stays set until a pulse on `rdy_clr[p]` clears it.
- R10: Each result is stored in a 16-bit result register on the edge that captures `conv_done`. Channel c occupies `result[16c+15:16c]`. With `fmt_frac` = 0 the 10-bit value sits in bits 9:0 with zeros above it. With `fmt_frac` = 1 it sits in bits 15:6 with zeros below it.
- R11: While `glb_en` = 1, `conv_tick` pulses once every 2·`clk_div_sel`+4 cycles. The value 3'b101 gives a period of 14 cycles.
- R12: When several pairs are pending, the lowest-numbered pair is converted first. `conv_req` holds a stable `conv_ch` until `conv_done`, so only one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Module enable |
| eie_wr | input | 1 | Write strobe for the interrupt-point bit |
| eie_wdata | input | 1 | Value written to the interrupt-point bit |
| order_odd | input | 1 | 1: odd channel converted first |
| fmt_frac | input | 1 | 1: left-justified (fractional) results |
| clk_div_sel | input | 3 | Conversion clock divider select |
| irq_en | input | 6 | Per-pair interrupt enable |
| src_sel | input | 30 | Per-pair 5-bit trigger source code |
| trig_bus | input | 32 | Trigger pulses indexed by source code |
| sw_trig_set | input | 6 | Per-pair software trigger request pulse |
| rdy_clr | input | 6 | Per-pair ready flag clear pulse |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| conv_req | output | 1 | Conversion request to the converter |
| conv_ch | output | 4 | Channel to be converted |
| conv_tick | output | 1 | Divided conversion clock tick |
| eie | output | 1 | Current interrupt-point bit |
| sw_trig | output | 6 | Per-pair software trigger bits |
| pend | output | 6 | Per-pair pending flags |
| rdy | output | 6 | Per-pair sticky ready flags |
| irq | output | 6 | Per-pair interrupt pulses |
| result | output | 192 | Twelve 16-bit result registers |

## Verification
An accepted trigger shows as `pend` and a cleared `sw_trig` one edge after the trigger. `conv_req` follows one edge later. Results, `irq` in early mode, and in the second half also `rdy` and the fall of `pend`, all change on the same edge that captures `conv_done`. The bench's converter model drives `conv_done` and then samples these outputs at the very next falling edge, and it checks one edge later that `irq` has dropped. Its expected values come from its own copy of the order, format and interrupt-point settings. A scoreboard queue holds the expected channel sequence, and each new request is compared against it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_SECOND = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_n, term;
  logic             tick_q, tick_n;

  assign term = CNT_W'({sel, 1'b0}) + CNT_W'(3);

  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (!en) begin
      cnt_n = '0;
    end else if (cnt_q >= term) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;

  // R11
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
endmodule

// File: rtl/adc_pair_ctrl.sv
module adc_pair_ctrl #(
  parameter int SRC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SRC_W-1:0]    src_sel,
  input  logic [2**SRC_W-1:0] trig_bus,
  input  logic                sw_set,
  input  logic                rdy_clr,
  input  logic                done_pulse,
  output logic                sw_trig,
  output logic                pend,
  output logic                rdy
);
  logic sw_q, sw_n, pend_q, pend_n, rdy_q, rdy_n;
  logic hw_hit, accept;

  assign hw_hit = (src_sel != '0) && trig_bus[src_sel];
  assign accept = en && !pend_q && (sw_q || hw_hit);

  always_comb begin
    sw_n   = sw_q | (sw_set & ~pend_q);
    pend_n = pend_q;
    rdy_n  = rdy_q;
    if (accept) begin
      sw_n   = 1'b0;
      pend_n = 1'b1;
    end
    if (done_pulse) pend_n = 1'b0;
    if (rdy_clr)    rdy_n  = 1'b0;
    if (done_pulse) rdy_n  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      pend_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      sw_q   <= sw_n;
      pend_q <= pend_n;
      rdy_q  <= rdy_n;
    end
  end

  assign sw_trig = sw_q;
  assign pend    = pend_q;
  assign rdy     = rdy_q;

  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en));
  // R4
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !sw_q);
  // R9
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rdy_q) && !$past(rdy_clr)) |-> rdy_q);
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int NP    = 6,
  parameter int RES_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             pend,
  input  logic                      order_odd,
  input  logic                      eie,
  input  logic                      conv_done,
  output logic                      conv_req,
  output logic [$clog2(NP):0]       conv_ch,
  output logic                      wr_en,
  output logic [NP-1:0]             pair_done,
  output logic [NP-1:0]             irq_point
);
  localparam int PAIR_W = $clog2(NP);

  seq_state_e      state_q, state_n;
  logic [PAIR_W-1:0] cur_q, cur_n, pick;
  logic              odd_bit;

  always_comb begin
    pick = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (pend[i]) pick = PAIR_W'(i);
    end
  end

  always_comb begin
    state_n = state_q;
    cur_n   = cur_q;
    case (state_q)
      SQ_IDLE:   if (|pend) begin state_n = SQ_FIRST; cur_n = pick; end
      SQ_FIRST:  if (conv_done) state_n = SQ_SECOND;
      SQ_SECOND: if (conv_done) state_n = SQ_IDLE;
      default:   state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
    end
  end

  assign odd_bit  = order_odd ^ (state_q == SQ_SECOND);
  assign conv_req = (state_q != SQ_IDLE);
  assign conv_ch  = {cur_q, odd_bit};
  assign wr_en    = conv_req && conv_done;

  for (genvar g = 0; g < NP; g++) begin : g_pair_evt
    logic hit;
    assign hit          = conv_done && (cur_q == PAIR_W'(g));
    assign pair_done[g] = hit && (state_q == SQ_SECOND);
    assign irq_point[g] = hit && (((state_q == SQ_FIRST) && eie) ||
                                  ((state_q == SQ_SECOND) && !eie));
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_ch)));
  // R5
  done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pair_done) |-> ((pair_done & pend) == pair_done));
endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_seq_pkg::*;
#(
  parameter int NP    = 6,
  parameter int RES_W = 10,
  parameter int OUT_W = 16,
  parameter int SRC_W = 5,
  parameter int DIV_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic                    eie_wr,
  input  logic                    eie_wdata,
  input  logic                    order_odd,
  input  logic                    fmt_frac,
  input  logic [DIV_W-1:0]        clk_div_sel,
  input  logic [NP-1:0]           irq_en,
  input  logic [NP*SRC_W-1:0]     src_sel,
  input  logic [2**SRC_W-1:0]     trig_bus,
  input  logic [NP-1:0]           sw_trig_set,
  input  logic [NP-1:0]           rdy_clr,
  input  logic                    conv_done,
  input  logic [RES_W-1:0]        conv_data,
  output logic                    conv_req,
  output logic [$clog2(NP):0]     conv_ch,
  output logic                    conv_tick,
  output logic                    eie,
  output logic [NP-1:0]           sw_trig,
  output logic [NP-1:0]           pend,
  output logic [NP-1:0]           rdy,
  output logic [NP-1:0]           irq,
  output logic [2*NP*OUT_W-1:0]   result
);
  localparam int NCH  = 2 * NP;
  localparam int CH_W = $clog2(NP) + 1;
  localparam int PADW = OUT_W - RES_W;

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic             eie_q, eie_n;
  logic [NP-1:0]    irq_q, irq_n;
  logic [NP-1:0]    pair_done, irq_point;
  logic             wr_en;
  logic [OUT_W-1:0] wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    eie_n = eie_q;
    if (eie_wr && !glb_en) eie_n = eie_wdata;
    irq_n = irq_point & irq_en;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      eie_q <= 1'b0;
      irq_q <= '0;
    end else begin
      eie_q <= eie_n;
      irq_q <= irq_n;
    end
  end

  assign eie = eie_q;
  assign irq = irq_q;

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i), .en(glb_en), .sel(clk_div_sel), .tick(conv_tick)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    adc_pair_ctrl #(.SRC_W(SRC_W)) u_pair (
      .clk(clk), .rst_n(rst_i), .en(glb_en),
      .src_sel(src_sel[p*SRC_W +: SRC_W]), .trig_bus(trig_bus),
      .sw_set(sw_trig_set[p]), .rdy_clr(rdy_clr[p]),
      .done_pulse(pair_done[p]),
      .sw_trig(sw_trig[p]), .pend(pend[p]), .rdy(rdy[p])
    );
  end

  adc_seq_core #(.NP(NP), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .pend(pend), .order_odd(order_odd), .eie(eie_q),
    .conv_done(conv_done), .conv_req(conv_req), .conv_ch(conv_ch),
    .wr_en(wr_en), .pair_done(pair_done), .irq_point(irq_point)
  );

  assign wr_val = fmt_frac ? {conv_data, {PADW{1'b0}}} : {{PADW{1'b0}}, conv_data};

  for (genvar c = 0; c < NCH; c++) begin : g_res
    logic [OUT_W-1:0] res_q, res_n;
    always_comb begin
      res_n = res_q;
      if (wr_en && (conv_ch == CH_W'(c))) res_n = wr_val;
    end
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) res_q <= '0;
      else        res_q <= res_n;
    end
    assign result[c*OUT_W +: OUT_W] = res_q;
  end

  // R2
  eie_lock_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $past(glb_en) |-> $stable(eie_q));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_q & ~$past(irq_en)) == '0);
endmodule

// File: tb/adc_pair_seq_tb.sv
module adc_pair_seq_tb_top;
  localparam int NP  = 6;
  localparam int LAT = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            glb_en = 0, eie_wr = 0, eie_wdata = 0, order_odd = 0, fmt_frac = 0;
  logic [2:0]      clk_div_sel = 3'd5;
  logic [NP-1:0]   irq_en = '0, sw_trig_set = '0, rdy_clr = '0;
  logic [NP*5-1:0] src_sel = '0;
  logic [31:0]     trig_bus = '0;
  logic            conv_done = 0;
  logic [9:0]      conv_data = '0;
  logic            conv_req, conv_tick, eie;
  logic [3:0]      conv_ch;
  logic [NP-1:0]   sw_trig, pend, rdy, irq;
  logic [2*NP*16-1:0] result;

  int n_chk = 0, n_fail = 0, n_conv = 0;
  bit exp_eie = 0, finished = 0;
  int exp_ch_q[$];

  always #10 clk = ~clk;

  adc_pair_seq dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .eie_wr(eie_wr), .eie_wdata(eie_wdata),
    .order_odd(order_odd), .fmt_frac(fmt_frac), .clk_div_sel(clk_div_sel),
    .irq_en(irq_en), .src_sel(src_sel), .trig_bus(trig_bus), .sw_trig_set(sw_trig_set),
    .rdy_clr(rdy_clr), .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_tick(conv_tick), .eie(eie),
    .sw_trig(sw_trig), .pend(pend), .rdy(rdy), .irq(irq), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (pend == '0 && !conv_req && exp_ch_q.size() == 0) return;
    end
    chk(0, "R5 idle timeout", pend, 0);
  endtask

  // converter model and result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        int ch, pr, exp;
        bit second;
        logic [9:0] d;
        logic [15:0] fv;
        ch = conv_ch;
        pr = ch / 2;
        exp = (exp_ch_q.size() > 0) ? exp_ch_q.pop_front() : -1;
        chk(ch == exp, "R3 R12 channel order", ch, exp);
        second = n_conv[0];
        n_conv++;
        d = (n_conv == 1) ? 10'h3FF : 10'((ch * 85 + n_conv * 7) & 10'h3FF);
        repeat (LAT - 1) @(negedge clk);
        conv_done = 1; conv_data = d;
        @(negedge clk);
        conv_done = 0;
        fv = fmt_frac ? {d, 6'b0} : {6'b0, d};
        chk(result[ch*16 +: 16] == fv, "R10 result format", result[ch*16 +: 16], fv);
        if (!second) begin
          chk(irq[pr] == (exp_eie & irq_en[pr]), "R8 first-half irq", irq[pr], exp_eie & irq_en[pr]);
          chk(pend[pr] == 1, "R5 pend held mid-pair", pend[pr], 1);
        end else begin
          chk(irq[pr] == (!exp_eie & irq_en[pr]), "R8 R7 second-half irq", irq[pr], !exp_eie & irq_en[pr]);
          chk(pend[pr] == 0, "R5 pend falls at completion", pend[pr], 0);
          chk(rdy[pr] == 1, "R9 ready set at completion", rdy[pr], 1);
        end
        @(negedge clk);
        chk(irq[pr] == 0, "R7 irq single pulse", irq[pr], 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  // driver
  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(pend == 0 && rdy == 0 && sw_trig == 0 && irq == 0, "R5 R9 reset flags", {pend, rdy, sw_trig, irq}, 0);
    chk(!conv_req && eie == 0 && result == '0, "R5 reset idle", conv_req, 0);

    // R1: triggers while disabled
    src_sel[5 +: 5] = 5'd12;
    sw_trig_set[0] = 1; trig_bus[12] = 1;
    @(negedge clk);
    sw_trig_set[0] = 0; trig_bus[12] = 0;
    repeat (4) @(negedge clk);
    chk(pend == 0 && !conv_req, "R1 disabled blocks triggers", pend, 0);
    chk(sw_trig[0] == 1, "R4 software trigger latched", sw_trig[0], 1);

    // R2: interrupt-point write allowed while disabled
    eie_wr = 1; eie_wdata = 1;
    @(negedge clk);
    chk(eie == 1, "R2 write while disabled", eie, 1);
    eie_wdata = 0;
    @(negedge clk);
    eie_wr = 0;
    chk(eie == 0, "R2 write back to 0", eie, 0);

    // enable: latched software trigger on pair 0 is accepted
    src_sel[5 +: 5] = 5'd0;
    src_sel[0 +: 5] = 5'd12;
    irq_en = 6'b000001;
    exp_ch_q.push_back(0); exp_ch_q.push_back(1);
    glb_en = 1;
    @(negedge clk);
    chk(pend[0] == 1 && sw_trig[0] == 0, "R4 R5 sw clears as pend sets", {pend[0], sw_trig[0]}, 2'b10);
    eie_wr = 1; eie_wdata = 1;
    trig_bus[12] = 1; sw_trig_set[0] = 1;
    @(negedge clk);
    eie_wr = 0; trig_bus[12] = 0; sw_trig_set[0] = 0;
    chk(eie == 0, "R2 write ignored while enabled", eie, 0);
    chk(sw_trig[0] == 0, "R4 sw set ignored while pending", sw_trig[0], 0);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(!conv_req && pend == 0, "R5 retrigger while pending ignored", pend, 0);
    chk(rdy[0] == 1, "R9 ready sticky", rdy[0], 1);
    rdy_clr[0] = 1;
    @(negedge clk);
    rdy_clr[0] = 0;
    chk(rdy[0] == 0, "R9 ready cleared", rdy[0], 0);

    // R6: source code 12 on pair 2, wrong bit ignored; irq disabled; fractional
    src_sel[0 +: 5] = 5'd0;
    src_sel[10 +: 5] = 5'd12;
    irq_en = 6'b000000;
    fmt_frac = 1;
    trig_bus[5] = 1;
    @(negedge clk);
    trig_bus[5] = 0;
    @(negedge clk);
    chk(pend == 0, "R6 unselected bus bit ignored", pend, 0);
    exp_ch_q.push_back(4); exp_ch_q.push_back(5);
    trig_bus[12] = 1;
    @(negedge clk);
    trig_bus[12] = 0;
    chk(pend == 6'b000100, "R6 timer-1 code triggers pair", pend, 6'b000100);
    wait_idle();

    // R8 early irq, R3 odd first, R12 lowest pair first
    glb_en = 0;
    @(negedge clk);
    eie_wr = 1; eie_wdata = 1;
    @(negedge clk);
    eie_wr = 0; exp_eie = 1;
    chk(eie == 1, "R2 early mode set", eie, 1);
    order_odd = 1; fmt_frac = 0; irq_en = 6'b111111;
    src_sel[10 +: 5] = 5'd0;
    foreach (exp_ch_q[i]) ;
    exp_ch_q.push_back(3); exp_ch_q.push_back(2);
    exp_ch_q.push_back(7); exp_ch_q.push_back(6);
    exp_ch_q.push_back(11); exp_ch_q.push_back(10);
    glb_en = 1;
    sw_trig_set = 6'b101010;
    @(negedge clk);
    sw_trig_set = '0;
    @(negedge clk);
    chk(pend == 6'b101010, "R12 all requested pairs pending", pend, 6'b101010);
    wait_idle();
    chk(rdy == 6'b101110, "R9 ready flags accumulate", rdy, 6'b101110);

    // R11 divider period
    for (int s = 0; s < 2; s++) begin
      int exp_p;
      clk_div_sel = (s == 0) ? 3'd5 : 3'd0;
      exp_p = (s == 0) ? 14 : 4;
      repeat (40) @(negedge clk);
      while (!conv_tick) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!conv_tick && gap < 100);
      chk(gap == exp_p, "R11 tick period", gap, exp_p);
    end

    chk(exp_ch_q.size() == 0, "R12 all expected conversions seen", exp_ch_q.size(), 0);
    summary();
  end
endmodule